// File: doc/BRIEF.md
# Floating-Point Status Register with Exception Traps

This block holds the 32-bit status word of a floating-point unit. Arithmetic units pulse raw exception events into it on any cycle: invalid operand, divide by zero, overflow, tiny result, accuracy loss on denormalisation, and inexact result. The block turns those events into sticky cumulative flags and follows two special rules. The underflow flag depends on its own trap enable. An enabled overflow or underflow trap overrides the inexact flag. When a raised flag also has its trap enable set, the block issues a trap request together with a cause vector.

A host port models the status write and status read transfers. A write replaces the trap enables, the control bits and the flags. A read returns the whole word, which includes a read-only implementation ID byte. The five control bits are also driven out as separate wires so that neighbouring units can use them directly: flush-to-zero, signalling-NaN store exception, synchronous operation, expanded decimal format and alternate compare carry.

Top module: `fpsr_trap_unit`

## Requirements
- R1: Bits 31:24 always read the parameter SYS_ID (default 0x81, bit 31 set for a hardware unit). Host writes to those bits have no effect.
- R2: After reset, every field other than the ID reads zero, so the read value is 0x81000000, and trap_req and trap_cause are 0.
- R3: The flags sit at bit 0 (invalid), bit 1 (divide by zero), bit 2 (overflow), bit 3 (underflow) and bit 4 (inexact). Once set, a flag stays set until a host write replaces it. When a host write and an event fall in the same cycle, the written value is applied first and the event flags are ORed on top.
- R4: An invalid or divide-by-zero event sets its flag on the next clock edge.
- R5: When the underflow trap is enabled (bit 19), a tiny event alone sets the underflow flag.
- R6: When the underflow trap is disabled, the underflow flag is set only if tiny and accuracy loss occur in the same cycle. In that case the inexact flag is also set.
- R7: The inexact flag is set by an inexact event, or by an overflow event while the overflow trap (bit 18) is disabled.
- R8: In a cycle where an enabled overflow or underflow trap fires, the inexact flag is not set by that cycle and no inexact trap is requested.
- R9: The control bits sit at bit 8 (flush-to-zero), bit 9 (NaN store exception), bit 10 (synchronous), bit 11 (expanded decimal) and bit 12 (alternate carry). Each one drives its own output.
- R10: Bits 23:21, 15:13 and 7:5 ignore written values and always read zero.
- R11: trap_cause is set for one cycle, on the edge after the events, for each flag raised in that cycle whose trap enable (bits 16 to 20, in flag order) was already set before the cycle. trap_req is the OR of trap_cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes the status word this cycle |
| host_wr_data | input | 32 | Value written by the host |
| host_rd_data | output | 32 | Current status word |
| ev_invalid | input | 1 | Invalid operation event |
| ev_divzero | input | 1 | Divide-by-zero event |
| ev_overflow | input | 1 | Overflow event |
| ev_tiny | input | 1 | Tiny non-zero result event |
| ev_accloss | input | 1 | Accuracy loss from denormalisation |
| ev_inexact | input | 1 | Rounded result inexact |
| trap_req | output | 1 | Trap request, one cycle |
| trap_cause | output | 5 | Flags that caused the trap, in flag order |
| ctl_flush_zero | output | 1 | Flush denormals to zero |
| ctl_nan_exc | output | 1 | Signalling-NaN store exception enable |
| ctl_sync | output | 1 | Synchronous operation |
| ctl_exp_packed | output | 1 | Expanded packed decimal format |
| ctl_alt_carry | output | 1 | Alternate compare carry definition |

## Verification
The bench drives a tiny event with the underflow trap enabled and again with it disabled, and drives tiny together with accuracy loss. A design that ignored the enable would set underflow on tininess alone, or would leave inexact clear in the untrapped case. It also drives overflow and inexact events with the overflow and inexact traps both enabled. A design that ignored the precedence rule would set the inexact flag or report an inexact trap cause. Further tests put a host write and an event in the same cycle, and enable a trap in the same cycle as its event. Those expose a design that drops the event or that traps on the enable value just written.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NFLAG    = 5;
  localparam int NCTRL    = 5;
  localparam int WORD_W   = 32;
  localparam int FLAG_LSB = 0;
  localparam int CTRL_LSB = 8;
  localparam int TEN_LSB  = 16;
  localparam int ID_LSB   = 24;
  localparam int ID_W     = 8;

  localparam int F_IVO = 0;
  localparam int F_DVZ = 1;
  localparam int F_OFL = 2;
  localparam int F_UFL = 3;
  localparam int F_INX = 4;

  typedef struct packed {
    logic invalid;
    logic divzero;
    logic overflow;
    logic tiny;
    logic accloss;
    logic inexact;
  } fp_events_t;

  // underflow rule: trap enabled -> tininess alone; else tininess with loss
  function automatic logic ufl_qualify(input logic tiny, input logic loss,
                                       input logic ufl_en);
    return tiny & (ufl_en | loss);
  endfunction

  // inexact contribution before precedence masking
  function automatic logic inx_raw(input logic inexact, input logic ofl,
                                   input logic ofl_en, input logic ufl,
                                   input logic ufl_en);
    return inexact | (ofl & ~ofl_en) | (ufl & ~ufl_en);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
      input logic [ID_W-1:0]  id,
      input logic [NFLAG-1:0] ten,
      input logic [NCTRL-1:0] ctl,
      input logic [NFLAG-1:0] flg);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_LSB   +: ID_W]  = id;
    w[TEN_LSB  +: NFLAG] = ten;
    w[CTRL_LSB +: NCTRL] = ctl;
    w[FLAG_LSB +: NFLAG] = flg;
    return w;
  endfunction
endpackage

// File: rtl/fpsr_event_qual.sv
module fpsr_event_qual
  import fpsr_pkg::*;
(
  input  fp_events_t       ev,
  input  logic [NFLAG-1:0] ten,
  output logic [NFLAG-1:0] raise,
  output logic             ufl_hit,
  output logic             big_trap
);
  logic inx_pre;

  always_comb begin
    ufl_hit  = ufl_qualify(ev.tiny, ev.accloss, ten[F_UFL]);
    big_trap = (ev.overflow & ten[F_OFL]) | (ufl_hit & ten[F_UFL]);
    inx_pre  = inx_raw(ev.inexact, ev.overflow, ten[F_OFL], ufl_hit, ten[F_UFL]);
    raise         = '0;
    raise[F_IVO]  = ev.invalid;
    raise[F_DVZ]  = ev.divzero;
    raise[F_OFL]  = ev.overflow;
    raise[F_UFL]  = ufl_hit;
    raise[F_INX]  = inx_pre & ~big_trap;
  end
endmodule

// File: rtl/fpsr_field_reg.sv
module fpsr_field_reg #(
  parameter int         W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (wr_en ? wr_val : q) | set_bits;
  end
endmodule

// File: rtl/fpsr_trap_gen.sv
module fpsr_trap_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] ten,
  output logic         trap_req,
  output logic [N-1:0] trap_cause
);
  logic [N-1:0] cause_d;

  for (genvar i = 0; i < N; i++) begin : g_cause
    assign cause_d[i] = raise[i] & ten[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_cause <= '0;
      trap_req   <= 1'b0;
    end else begin
      trap_cause <= cause_d;
      trap_req   <= |cause_d;
    end
  end
endmodule

// File: rtl/fpsr_trap_unit.sv
module fpsr_trap_unit
  import fpsr_pkg::*;
#(
  parameter logic [7:0] SYS_ID = 8'h81
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [31:0] host_wr_data,
  output logic [31:0] host_rd_data,
  input  logic        ev_invalid,
  input  logic        ev_divzero,
  input  logic        ev_overflow,
  input  logic        ev_tiny,
  input  logic        ev_accloss,
  input  logic        ev_inexact,
  output logic        trap_req,
  output logic [4:0]  trap_cause,
  output logic        ctl_flush_zero,
  output logic        ctl_nan_exc,
  output logic        ctl_sync,
  output logic        ctl_exp_packed,
  output logic        ctl_alt_carry
);
  fp_events_t       ev;
  logic [NFLAG-1:0] ten_q;
  logic [NCTRL-1:0] ctl_q;
  logic [NFLAG-1:0] flg_q;
  logic [NFLAG-1:0] raise;
  logic             ufl_hit;
  logic             big_trap;
  logic             unused_wr_bits;

  assign ev = '{invalid:  ev_invalid,  divzero: ev_divzero,
                overflow: ev_overflow, tiny:    ev_tiny,
                accloss:  ev_accloss,  inexact: ev_inexact};

  assign unused_wr_bits = ^{host_wr_data[31:21], host_wr_data[15:13],
                            host_wr_data[7:5]};

  fpsr_event_qual u_qual (
    .ev       (ev),
    .ten      (ten_q),
    .raise    (raise),
    .ufl_hit  (ufl_hit),
    .big_trap (big_trap)
  );

  fpsr_field_reg #(.W(NFLAG)) u_ten (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_val   (host_wr_data[TEN_LSB +: NFLAG]),
    .set_bits ({NFLAG{1'b0}}),
    .q        (ten_q)
  );

  fpsr_field_reg #(.W(NCTRL)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_val   (host_wr_data[CTRL_LSB +: NCTRL]),
    .set_bits ({NCTRL{1'b0}}),
    .q        (ctl_q)
  );

  fpsr_field_reg #(.W(NFLAG)) u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_val   (host_wr_data[FLAG_LSB +: NFLAG]),
    .set_bits (raise),
    .q        (flg_q)
  );

  fpsr_trap_gen #(.N(NFLAG)) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise      (raise),
    .ten        (ten_q),
    .trap_req   (trap_req),
    .trap_cause (trap_cause)
  );

  assign host_rd_data   = pack_word(SYS_ID, ten_q, ctl_q, flg_q);
  assign ctl_flush_zero = ctl_q[0];
  assign ctl_nan_exc    = ctl_q[1];
  assign ctl_sync       = ctl_q[2];
  assign ctl_exp_packed = ctl_q[3];
  assign ctl_alt_carry  = ctl_q[4];
endmodule

// File: rtl/fpsr_trap_unit_chk.sv
module fpsr_trap_unit_chk #(
  parameter logic [7:0] SYS_ID = 8'h81
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr_en,
  input logic [31:0] host_rd_data,
  input logic        ev_tiny,
  input logic        ufl_hit,
  input logic        trap_req,
  input logic [4:0]  trap_cause,
  input logic        ctl_flush_zero,
  input logic        ctl_alt_carry
);
  p_id_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[31:24] == SYS_ID);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[23:21] == 3'b0 && host_rd_data[15:13] == 3'b0 &&
    host_rd_data[7:5] == 3'b0);

  p_flags_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_en |=> (($past(host_rd_data[4:0]) & ~host_rd_data[4:0]) == 5'b0));

  p_ufl_needs_tiny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_hit |-> ev_tiny);

  p_inx_yields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cause[4] |-> (!trap_cause[2] && !trap_cause[3]));

  p_trap_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trap_cause & ~$past(host_rd_data[20:16])) == 5'b0));

  p_trap_req_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (trap_cause != 5'b0));

  p_ctl_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flush_zero == host_rd_data[8] && ctl_alt_carry == host_rd_data[12]);
endmodule

bind fpsr_trap_unit fpsr_trap_unit_chk #(.SYS_ID(SYS_ID)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr_en     (host_wr_en),
  .host_rd_data   (host_rd_data),
  .ev_tiny        (ev_tiny),
  .ufl_hit        (ufl_hit),
  .trap_req       (trap_req),
  .trap_cause     (trap_cause),
  .ctl_flush_zero (ctl_flush_zero),
  .ctl_alt_carry  (ctl_alt_carry)
);

// File: tb/fpsr_trap_unit_tb_top.sv
module fpsr_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;
  logic        ev_invalid = 0, ev_divzero = 0, ev_overflow = 0;
  logic        ev_tiny = 0, ev_accloss = 0, ev_inexact = 0;
  logic        trap_req;
  logic [4:0]  trap_cause;
  logic        ctl_flush_zero, ctl_nan_exc, ctl_sync, ctl_exp_packed, ctl_alt_carry;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_word;
  logic [4:0]  m_cause;

  // event bundle order: {invalid, divzero, overflow, tiny, accloss, inexact}
  localparam logic [5:0] E_IVO = 6'b100000;
  localparam logic [5:0] E_DVZ = 6'b010000;
  localparam logic [5:0] E_OFL = 6'b001000;
  localparam logic [5:0] E_TNY = 6'b000100;
  localparam logic [5:0] E_ACC = 6'b000010;
  localparam logic [5:0] E_INX = 6'b000001;

  always #5 clk = ~clk;

  fpsr_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .ev_invalid(ev_invalid), .ev_divzero(ev_divzero),
    .ev_overflow(ev_overflow), .ev_tiny(ev_tiny), .ev_accloss(ev_accloss),
    .ev_inexact(ev_inexact), .trap_req(trap_req), .trap_cause(trap_cause),
    .ctl_flush_zero(ctl_flush_zero), .ctl_nan_exc(ctl_nan_exc), .ctl_sync(ctl_sync),
    .ctl_exp_packed(ctl_exp_packed), .ctl_alt_carry(ctl_alt_carry));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " word"}, host_rd_data, m_word);
    check({tag, " cause"}, {27'b0, trap_cause}, {27'b0, m_cause});
    check({tag, " req"}, {31'b0, trap_req}, {31'b0, (m_cause != 5'b0)});
    check({tag, " ctl R9"},
          {27'b0, ctl_alt_carry, ctl_exp_packed, ctl_sync, ctl_nan_exc, ctl_flush_zero},
          {27'b0, m_word[12:8]});
  endtask

  // reference update written from the requirements
  task automatic model(input logic wr, input logic [31:0] wd, input logic [5:0] e);
    bit ivo, dvz, ofl, tny, acc, inx, en_ofl, en_ufl, ufl, hard, inx_flag;
    logic [4:0] ups, en_old;
    logic [31:0] nxt;
    {ivo, dvz, ofl, tny, acc, inx} = e;
    en_old = m_word[20:16];
    en_ofl = en_old[2];
    en_ufl = en_old[3];
    if (en_ufl) ufl = tny;            // R5
    else        ufl = tny && acc;     // R6
    hard = (ofl && en_ofl) || (ufl && en_ufl);
    inx_flag = inx || (ofl && !en_ofl) || (ufl && !en_ufl);   // R7
    if (hard) inx_flag = 0;           // R8
    ups = {inx_flag, ufl, ofl, dvz, ivo};
    nxt = wr ? (wd & 32'h001F1F1F) : m_word;   // R10
    nxt[31:24] = 8'h81;                        // R1
    nxt[4:0] = nxt[4:0] | ups;                 // R3
    m_cause = ups & en_old;                    // R11
    m_word = nxt;
  endtask

  task automatic step(input logic wr, input logic [31:0] wd, input logic [5:0] e,
                      input string tag);
    host_wr_en = wr;
    host_wr_data = wd;
    {ev_invalid, ev_divzero, ev_overflow, ev_tiny, ev_accloss, ev_inexact} = e;
    model(wr, wd, e);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_word = 32'h81000000;
    m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R2 reset");
    check("R1 id after reset", {24'b0, host_rd_data[31:24]}, 32'h81);

    step(1, 32'hFFFF_FFFF, 6'b0, "R1 R10 write all ones");
    check("R10 readback", host_rd_data, 32'h811F1F1F);
    step(1, 32'h0000_0000, 6'b0, "R3 clear by write");
    step(0, 0, E_IVO, "R4 invalid untrapped");
    step(0, 0, 6'b0,  "R3 sticky idle");
    step(1, 32'h0001_0000, 6'b0, "R3 write clears flags");
    step(0, 0, E_IVO, "R4 invalid trapped");
    check("R11 cause invalid", {27'b0, trap_cause}, 32'h1);
    step(0, 0, 6'b0, "R11 one cycle pulse");
    step(1, 32'h0000_0000, E_DVZ, "R3 write plus event same cycle");
    check("R3 dvz survives write", host_rd_data, 32'h8100_0002);
    step(1, 0, 6'b0, "clear");
    step(0, 0, E_TNY, "R6 tiny alone untrapped");
    check("R6 no ufl", host_rd_data, 32'h8100_0000);
    step(0, 0, E_TNY | E_ACC, "R6 tiny with loss");
    check("R6 ufl and inx", host_rd_data, 32'h8100_0018);
    step(1, 32'h0008_0000, 6'b0, "R5 enable ufl trap");
    step(0, 0, E_TNY | E_INX, "R5 R8 tiny trapped");
    check("R8 no inx with ufl trap", host_rd_data, 32'h8108_0008);
    step(1, 32'h0000_0000, E_OFL, "R7 overflow untrapped");
    check("R7 ofl plus inx", host_rd_data, 32'h8100_0014);
    step(1, 32'h0014_0000, 6'b0, "R8 enable ofl and inx traps");
    step(0, 0, E_OFL | E_INX, "R8 overflow trapped");
    check("R8 cause ofl only", {27'b0, trap_cause}, 32'h4);
    step(0, 0, E_INX, "R7 inexact trapped");
    check("R7 cause inx", {27'b0, trap_cause}, 32'h10);
    step(1, 32'h0000_0000, 6'b0, "clear");
    step(1, 32'h0001_0000, E_IVO, "R11 enable and event same cycle");
    check("R11 no trap on new enable", {31'b0, trap_req}, 32'h0);
    step(1, 32'h0000_1500, 6'b0, "R9 control pattern");
    step(1, 32'h0000_0A00, 6'b0, "R9 control pattern inverse");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] wd;
      logic [5:0]  e;
      logic        wr;
      wd = $urandom;
      e  = 6'($urandom);
      wr = ($urandom % 6) == 0;
      step(wr, wd, e, "random R3 R4 R5 R6 R7 R8 R11");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule